// File: doc/BRIEF.md
# LPC Bus Transaction Monitor

This block watches a Low Pin Count bus without ever driving it. It runs on a fast system clock. It finds the selected edge of the bus clock, and on each such edge it samples the active-low frame strobe and the 4-bit multiplexed address/data lines. It then steps each frame through its fields: start code, cycle type/direction, address, data, turn-around and SYNC. When a frame completes, it presents a record for exactly one system clock. The record holds the decoded header, the address, the data byte and a set of protocol-violation flags.

I/O and memory reads and writes are decoded fully. Any other frame is reported as soon as its header is known: DMA cycles, a reserved cycle type, bus-master grants, or unrecognised start codes. The frame strobe going low in the middle of a frame discards that frame and starts decoding a new one. The bus clock and the sampled lines are assumed to be already synchronous to the system clock, which must run at least twice as fast as the bus clock.

Top module: `lpc_mon`

## Requirements
- R1: When `fall_sel_i` is 0, sampling happens on rising edges of `lclk_i`. When it is 1, sampling happens on falling edges. Edges of the other polarity have no effect.
- R2: A frame opens on a sample with `lframe_ni` low. While the strobe stays low, the start code is overwritten on every sample, so the value on the last low sample is the one kept. `rec_kind_o` reports that code as follows: 0 for code 0000, 1 for code 0101 (TPM), 2 for codes 0010 and 0011 (bus-master grant 0/1), and 3 for any other code.
- R3: If the lines change value between two consecutive low-strobe samples, `rec_lad_chg_o` is set in that frame's record.
- R4: The nibble on the first sample with the strobe high is the cycle-type nibble. Bits [3:2] give the type (00 I/O, 01 memory, 10 DMA, 11 reserved) and bit [1] gives the direction (1 = write). A reserved type sets `rec_bad_type_o`.
- R5: An I/O frame carries 4 address nibbles and a memory frame carries 8. Nibbles arrive most significant first. An I/O address is zero-extended to 32 bits.
- R6: The data byte takes two samples, low nibble first. In a write it follows the address. In a read it follows SYNC.
- R7: Each turn-around phase lasts two samples. A value other than 1111 on any of those samples sets `rec_tar_warn_o`. The first phase follows the write data or the read address, and the second phase closes the frame.
- R8: During SYNC, 0101 and 0110 are wait states and may repeat. 0000 ends SYNC normally, and 1010 ends it and sets `rec_sync_err_o`. Any other value sets `rec_bad_sync_o` and is treated as a wait.
- R9: `rec_valid_o` is high for exactly one system clock, in the cycle right after the sampling edge of the frame's last field. A frame whose start kind is 2 or 3, or whose type is DMA or reserved, ends at its cycle-type sample, with address and data reported as zero.
- R10: A low strobe on any sample after the cycle-type nibble aborts the current frame without a record, and that sample is taken as a new start code.
- R11: After reset, `rec_valid_o` is 0 and every record field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lclk_i | input | 1 | Bus clock, sampled |
| lframe_ni | input | 1 | Frame strobe, active low |
| lad_i | input | 4 | Multiplexed address/data lines |
| fall_sel_i | input | 1 | 1 selects falling bus-clock edges |
| rec_valid_o | output | 1 | Record valid pulse |
| rec_start_o | output | 4 | Start code |
| rec_kind_o | output | 2 | Start code class |
| rec_type_o | output | 2 | Cycle type |
| rec_write_o | output | 1 | Direction, 1 = write |
| rec_addr_o | output | 32 | Address |
| rec_data_o | output | 8 | Data byte |
| rec_sync_err_o | output | 1 | SYNC ended with error code |
| rec_lad_chg_o | output | 1 | Lines changed during start |
| rec_bad_type_o | output | 1 | Reserved cycle type |
| rec_tar_warn_o | output | 1 | Turn-around value not 1111 |
| rec_bad_sync_o | output | 1 | Unknown SYNC code seen |

## Verification
Frames are driven in both field orders, using distinct address and data values. A swapped nibble order, or data captured in the wrong phase, therefore shows up as a wrong value. SYNC is exercised with no waits, with short waits, with long waits, with an unknown code and with the error code, which separates progression from flagging. Runs with stretched or changing start codes, header-only frames and a mid-frame abort test the start and restart logic. The same frames are then replayed on falling edges, to show that only the selected edge advances the decoder.

// File: rtl/lpc_mon_pkg.sv
package lpc_mon_pkg;

  localparam int unsigned NIB_W     = 4;
  localparam int unsigned DATA_NIBS = 2;
  localparam int unsigned DATA_W    = DATA_NIBS * NIB_W;
  localparam int unsigned TAR_LEN   = 2;

  localparam logic [3:0] SYNC_READY = 4'b0000;
  localparam logic [3:0] SYNC_SHORT = 4'b0101;
  localparam logic [3:0] SYNC_LONG  = 4'b0110;
  localparam logic [3:0] SYNC_ERR   = 4'b1010;
  localparam logic [3:0] TAR_IDLE   = 4'b1111;

  typedef enum logic [1:0] {
    KIND_TARGET = 2'd0,
    KIND_TPM    = 2'd1,
    KIND_GRANT  = 2'd2,
    KIND_OTHER  = 2'd3
  } start_kind_e;

  typedef enum logic [1:0] {
    CT_IO   = 2'd0,
    CT_MEM  = 2'd1,
    CT_DMA  = 2'd2,
    CT_RSVD = 2'd3
  } cyc_type_e;

  typedef enum logic [2:0] {
    FS_IDLE, FS_START, FS_ADDR, FS_WDATA, FS_TAR1, FS_SYNC, FS_RDATA, FS_TAR2
  } field_e;

  typedef struct packed {
    logic lad_chg;
    logic bad_type;
    logic tar_warn;
    logic bad_sync;
    logic sync_err;
  } flags_t;

  function automatic start_kind_e kind_of(input logic [3:0] code);
    case (code)
      4'b0000:          kind_of = KIND_TARGET;
      4'b0101:          kind_of = KIND_TPM;
      4'b0010, 4'b0011: kind_of = KIND_GRANT;
      default:          kind_of = KIND_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/lpc_mon_edge.sv
module lpc_mon_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lclk_i,
  input  logic fall_sel_i,
  output logic stb_o
);

  logic lclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lclk_q <= 1'b0;
    else         lclk_q <= lclk_i;
  end

  assign stb_o = fall_sel_i ? (lclk_q & ~lclk_i) : (~lclk_q & lclk_i);

endmodule

// File: rtl/lpc_mon_fsm.sv
module lpc_mon_fsm
  import lpc_mon_pkg::*;
#(
  parameter int unsigned IO_NIBS  = 4,
  parameter int unsigned MEM_NIBS = 8,
  localparam int unsigned ADDR_W  = MEM_NIBS * NIB_W,
  localparam int unsigned CNT_W   = (MEM_NIBS > 2) ? $clog2(MEM_NIBS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              lframe_ni,
  input  logic [3:0]        lad_i,
  output logic              done_o,
  output logic [3:0]        start_o,
  output cyc_type_e         ctype_o,
  output logic              write_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output flags_t            flags_o
);

  field_e              state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [3:0]          start_q, start_d;
  cyc_type_e           ctype_q, ctype_d;
  logic                write_q, write_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [DATA_W-1:0]   data_q, data_d;
  flags_t              flags_q, flags_d;
  logic                done;
  logic [CNT_W-1:0]    last_nib;
  start_kind_e         kind;

  assign last_nib = (ctype_q == CT_IO) ? CNT_W'(IO_NIBS - 1) : CNT_W'(MEM_NIBS - 1);
  assign kind     = kind_of(start_q);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    start_d = start_q;
    ctype_d = ctype_q;
    write_d = write_q;
    addr_d  = addr_q;
    data_d  = data_q;
    flags_d = flags_q;
    done    = 1'b0;
    if (stb_i) begin
      if (!lframe_ni && state_q != FS_START) begin
        // new frame or abort of the running one
        state_d = FS_START;
        start_d = lad_i;
        cnt_d   = '0;
        addr_d  = '0;
        data_d  = '0;
        flags_d = '0;
        ctype_d = CT_IO;
        write_d = 1'b0;
      end else begin
        unique case (state_q)
          FS_IDLE: ;
          FS_START: begin
            if (!lframe_ni) begin
              if (lad_i != start_q) flags_d.lad_chg = 1'b1;
              start_d = lad_i;
            end else begin
              ctype_d = cyc_type_e'(lad_i[3:2]);
              write_d = lad_i[1];
              flags_d.bad_type = (lad_i[3:2] == CT_RSVD);
              cnt_d   = '0;
              if ((kind == KIND_TARGET || kind == KIND_TPM) && !lad_i[3]) begin
                state_d = FS_ADDR;
              end else begin
                state_d = FS_IDLE;
                done    = 1'b1;
              end
            end
          end
          FS_ADDR: begin
            addr_d = {addr_q[ADDR_W-NIB_W-1:0], lad_i};
            if (cnt_q == last_nib) begin
              cnt_d   = '0;
              state_d = write_q ? FS_WDATA : FS_TAR1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          FS_WDATA, FS_RDATA: begin
            data_d[cnt_q[0]*NIB_W +: NIB_W] = lad_i;
            if (cnt_q == CNT_W'(DATA_NIBS - 1)) begin
              cnt_d   = '0;
              state_d = (state_q == FS_WDATA) ? FS_TAR1 : FS_TAR2;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          FS_TAR1, FS_TAR2: begin
            if (lad_i != TAR_IDLE) flags_d.tar_warn = 1'b1;
            if (cnt_q == CNT_W'(TAR_LEN - 1)) begin
              cnt_d = '0;
              if (state_q == FS_TAR1) begin
                state_d = FS_SYNC;
              end else begin
                state_d = FS_IDLE;
                done    = 1'b1;
              end
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          FS_SYNC: begin
            case (lad_i)
              SYNC_READY, SYNC_ERR: begin
                if (lad_i == SYNC_ERR) flags_d.sync_err = 1'b1;
                state_d = write_q ? FS_TAR2 : FS_RDATA;
              end
              SYNC_SHORT, SYNC_LONG: ;
              default: flags_d.bad_sync = 1'b1;
            endcase
          end
          default: state_d = FS_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      cnt_q   <= '0;
      start_q <= '0;
      ctype_q <= CT_IO;
      write_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      flags_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      start_q <= start_d;
      ctype_q <= ctype_d;
      write_q <= write_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      flags_q <= flags_d;
    end
  end

  assign done_o  = done;
  assign start_o = start_d;
  assign ctype_o = ctype_d;
  assign write_o = write_d;
  assign addr_o  = addr_d;
  assign data_o  = data_d;
  assign flags_o = flags_d;

endmodule

// File: rtl/lpc_mon.sv
module lpc_mon
  import lpc_mon_pkg::*;
#(
  parameter int unsigned IO_NIBS  = 4,
  parameter int unsigned MEM_NIBS = 8,
  localparam int unsigned ADDR_W  = MEM_NIBS * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lclk_i,
  input  logic              lframe_ni,
  input  logic [3:0]        lad_i,
  input  logic              fall_sel_i,
  output logic              rec_valid_o,
  output logic [3:0]        rec_start_o,
  output logic [1:0]        rec_kind_o,
  output logic [1:0]        rec_type_o,
  output logic              rec_write_o,
  output logic [ADDR_W-1:0] rec_addr_o,
  output logic [DATA_W-1:0] rec_data_o,
  output logic              rec_sync_err_o,
  output logic              rec_lad_chg_o,
  output logic              rec_bad_type_o,
  output logic              rec_tar_warn_o,
  output logic              rec_bad_sync_o
);

  logic              sample_stb;
  logic              frame_done;
  logic [3:0]        w_start;
  cyc_type_e         w_ctype;
  logic              w_write;
  logic [ADDR_W-1:0] w_addr;
  logic [DATA_W-1:0] w_data;
  flags_t            w_flags;

  lpc_mon_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lclk_i     (lclk_i),
    .fall_sel_i (fall_sel_i),
    .stb_o      (sample_stb)
  );

  lpc_mon_fsm #(
    .IO_NIBS  (IO_NIBS),
    .MEM_NIBS (MEM_NIBS)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (sample_stb),
    .lframe_ni (lframe_ni),
    .lad_i     (lad_i),
    .done_o    (frame_done),
    .start_o   (w_start),
    .ctype_o   (w_ctype),
    .write_o   (w_write),
    .addr_o    (w_addr),
    .data_o    (w_data),
    .flags_o   (w_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_valid_o    <= 1'b0;
      rec_start_o    <= '0;
      rec_kind_o     <= '0;
      rec_type_o     <= '0;
      rec_write_o    <= 1'b0;
      rec_addr_o     <= '0;
      rec_data_o     <= '0;
      rec_sync_err_o <= 1'b0;
      rec_lad_chg_o  <= 1'b0;
      rec_bad_type_o <= 1'b0;
      rec_tar_warn_o <= 1'b0;
      rec_bad_sync_o <= 1'b0;
    end else begin
      rec_valid_o <= frame_done;
      if (frame_done) begin
        rec_start_o    <= w_start;
        rec_kind_o     <= kind_of(w_start);
        rec_type_o     <= w_ctype;
        rec_write_o    <= w_write;
        rec_addr_o     <= w_addr;
        rec_data_o     <= w_data;
        rec_sync_err_o <= w_flags.sync_err;
        rec_lad_chg_o  <= w_flags.lad_chg;
        rec_bad_type_o <= w_flags.bad_type;
        rec_tar_warn_o <= w_flags.tar_warn;
        rec_bad_sync_o <= w_flags.bad_sync;
      end
    end
  end

endmodule

// File: rtl/lpc_mon_chk.sv
module lpc_mon_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stb_i,
  input logic              lframe_ni,
  input logic              rec_valid_i,
  input logic [3:0]        rec_start_i,
  input logic [1:0]        rec_kind_i,
  input logic [1:0]        rec_type_i,
  input logic [ADDR_W-1:0] rec_addr_i,
  input logic [7:0]        rec_data_i,
  input logic              rec_bad_type_i
);

  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i |=> !rec_valid_i);

  p_valid_after_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i |-> $past(stb_i));

  p_abort_no_record_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !lframe_ni) |=> !rec_valid_i);

  p_io_addr_ext_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_i && rec_type_i == 2'b00) |-> (rec_addr_i[ADDR_W-1:16] == '0));

  p_header_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_i && rec_type_i[1]) |-> (rec_addr_i == '0 && rec_data_i == '0));

  p_bad_type_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i |-> (rec_bad_type_i == (rec_type_i == 2'b11)));

  p_tpm_kind_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_i && rec_start_i == 4'b0101) |-> (rec_kind_i == 2'd1));

endmodule

bind lpc_mon lpc_mon_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .stb_i          (sample_stb),
  .lframe_ni      (lframe_ni),
  .rec_valid_i    (rec_valid_o),
  .rec_start_i    (rec_start_o),
  .rec_kind_i     (rec_kind_o),
  .rec_type_i     (rec_type_o),
  .rec_addr_i     (rec_addr_o),
  .rec_data_i     (rec_data_o),
  .rec_bad_type_i (rec_bad_type_o)
);

// File: tb/lpc_mon_tb.sv
module lpc_mon_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lclk = 1'b0;
  logic        lframe_n = 1'b1;
  logic [3:0]  lad = 4'hF;
  logic        fall_sel = 1'b0;

  logic        rec_valid;
  logic [3:0]  rec_start;
  logic [1:0]  rec_kind, rec_type;
  logic        rec_write;
  logic [31:0] rec_addr;
  logic [7:0]  rec_data;
  logic        rec_sync_err, rec_lad_chg, rec_bad_type, rec_tar_warn, rec_bad_sync;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  string cur_req = "R11";

  // expected record: start,kind,type,write,addr,data,sync_err,lad_chg,bad_type,tar_warn,bad_sync
  logic [54:0] exp_rec;

  always #10 clk = ~clk;

  lpc_mon u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .lclk_i         (lclk),
    .lframe_ni      (lframe_n),
    .lad_i          (lad),
    .fall_sel_i     (fall_sel),
    .rec_valid_o    (rec_valid),
    .rec_start_o    (rec_start),
    .rec_kind_o     (rec_kind),
    .rec_type_o     (rec_type),
    .rec_write_o    (rec_write),
    .rec_addr_o     (rec_addr),
    .rec_data_o     (rec_data),
    .rec_sync_err_o (rec_sync_err),
    .rec_lad_chg_o  (rec_lad_chg),
    .rec_bad_type_o (rec_bad_type),
    .rec_tar_warn_o (rec_tar_warn),
    .rec_bad_sync_o (rec_bad_sync)
  );

  function automatic logic [54:0] got_rec();
    return {rec_start, rec_kind, rec_type, rec_write, rec_addr, rec_data,
            rec_sync_err, rec_lad_chg, rec_bad_type, rec_tar_warn, rec_bad_sync};
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ev);
    n_chk++;
    if (rec_valid !== ev) begin
      n_fail++;
      $display("FAIL %s: rec_valid got %0b exp %0b", cur_req, rec_valid, ev);
    end else if (ev && got_rec() !== exp_rec) begin
      n_fail++;
      $display("FAIL %s: record got %h exp %h", cur_req, got_rec(), exp_rec);
    end
  endtask

  // one bus clock: data set, rising edge, falling edge; record checked every system clock
  task automatic tick(input logic fr, input logic [3:0] v, input bit emit);
    @(negedge clk); lframe_n = fr; lad = v; chk(0);
    @(negedge clk); lclk = 1'b1; chk(0);
    @(negedge clk); chk(emit && !fall_sel);
    @(negedge clk); lclk = 1'b0; chk(0);
    @(negedge clk); chk(emit && fall_sel);
  endtask

  function automatic logic [1:0] kind_exp(input logic [3:0] c);
    if (c == 4'b0000) return 2'd0;
    if (c == 4'b0101) return 2'd1;
    if (c == 4'b0010 || c == 4'b0011) return 2'd2;
    return 2'd3;
  endfunction

  task automatic run_frame(input string req, input bit use_pre, input logic [3:0] pre,
                           input logic [3:0] st, input logic [1:0] ty, input logic wr,
                           input logic [31:0] ad, input logic [7:0] dt, input int nwait,
                           input logic [3:0] wcode, input logic [3:0] ecode,
                           input logic [3:0] tval);
    bit    dec;
    int    nibs;
    logic [31:0] ea;
    cur_req = req;
    dec  = (kind_exp(st) <= 2'd1) && (ty <= 2'd1);
    nibs = (ty == 2'd0) ? 4 : 8;
    ea   = !dec ? 32'h0 : (ty == 2'd0) ? {16'h0, ad[15:0]} : ad;
    exp_rec = {st, kind_exp(st), ty, wr, ea, dec ? dt : 8'h0,
               dec && ecode == 4'b1010,
               use_pre && pre != st,
               ty == 2'd3,
               dec && tval != 4'hF,
               dec && nwait > 0 && wcode != 4'b0101 && wcode != 4'b0110};
    if (use_pre) tick(1'b0, pre, 1'b0);
    tick(1'b0, st, 1'b0);
    tick(1'b1, {ty, wr, 1'b0}, !dec);
    if (dec) begin
      for (int i = nibs - 1; i >= 0; i--) tick(1'b1, ad[i*4 +: 4], 1'b0);
      if (wr) begin
        tick(1'b1, dt[3:0], 1'b0);
        tick(1'b1, dt[7:4], 1'b0);
      end
      tick(1'b1, tval, 1'b0);
      tick(1'b1, tval, 1'b0);
      for (int i = 0; i < nwait; i++) tick(1'b1, wcode, 1'b0);
      tick(1'b1, ecode, 1'b0);
      if (!wr) begin
        tick(1'b1, dt[3:0], 1'b0);
        tick(1'b1, dt[7:4], 1'b0);
      end
      tick(1'b1, tval, 1'b0);
      tick(1'b1, tval, 1'b1);
    end
    tick(1'b1, 4'hF, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    cur_req = "R11";
    n_chk++;
    if (rec_valid !== 1'b0 || got_rec() !== '0) begin
      n_fail++;
      $display("FAIL R11: record got %b/%h exp 0/0", rec_valid, got_rec());
    end

    // R5 R6 R8: I/O read, short waits
    run_frame("R6", 0, 0, 4'h0, 2'd0, 1'b0, 32'hFFFF_1234, 8'h5C, 2, 4'b0101, 4'b0000, 4'hF);
    // R6: I/O write, no waits
    run_frame("R6", 0, 0, 4'h0, 2'd0, 1'b1, 32'h0000_80A1, 8'hA5, 0, 4'b0101, 4'b0000, 4'hF);
    // R5 R8: memory read, long waits, error end
    run_frame("R8", 0, 0, 4'h0, 2'd1, 1'b0, 32'hDEAD_BEEF, 8'h3E, 3, 4'b0110, 4'b1010, 4'hF);
    // R8: memory write, unknown sync code treated as wait
    run_frame("R8", 0, 0, 4'h0, 2'd1, 1'b1, 32'h0123_4567, 8'h81, 2, 4'b0011, 4'b0000, 4'hF);
    // R7: turn-around not all ones
    run_frame("R7", 0, 0, 4'h0, 2'd0, 1'b0, 32'h0000_0F0F, 8'h77, 1, 4'b0101, 4'b0000, 4'hE);
    // R2: TPM start code
    run_frame("R2", 0, 0, 4'b0101, 2'd0, 1'b1, 32'h0000_0D40, 8'h19, 0, 4'b0101, 4'b0000, 4'hF);
    // R3: stretched start with changing code
    run_frame("R3", 1, 4'b0001, 4'h0, 2'd0, 1'b0, 32'h0000_2468, 8'hC3, 0, 4'b0101, 4'b0000, 4'hF);
    // R2: stretched start, same code, last code kept with no flag
    run_frame("R2", 1, 4'b0101, 4'b0101, 2'd1, 1'b0, 32'h1357_9BDF, 8'h0F, 1, 4'b0110, 4'b0000, 4'hF);
    // R9: DMA header only
    run_frame("R9", 0, 0, 4'h0, 2'd2, 1'b1, 32'h0, 8'h0, 0, 4'b0101, 4'b0000, 4'hF);
    // R9: grant start header only
    run_frame("R9", 0, 0, 4'b0010, 2'd0, 1'b0, 32'h0, 8'h0, 0, 4'b0101, 4'b0000, 4'hF);
    // R4: reserved cycle type
    run_frame("R4", 0, 0, 4'h0, 2'd3, 1'b0, 32'h0, 8'h0, 0, 4'b0101, 4'b0000, 4'hF);

    // R10: abort a memory frame during its address, no record, then complete
    cur_req = "R10";
    tick(1'b0, 4'h0, 1'b0);
    tick(1'b1, 4'b0100, 1'b0);
    tick(1'b1, 4'h9, 1'b0);
    tick(1'b1, 4'h8, 1'b0);
    run_frame("R10", 0, 0, 4'h0, 2'd0, 1'b1, 32'h0000_5A5A, 8'h42, 0, 4'b0101, 4'b0000, 4'hF);

    // R1: falling-edge sampling
    fall_sel = 1'b1;
    run_frame("R1", 0, 0, 4'h0, 2'd0, 1'b0, 32'h0000_BEAD, 8'hE1, 1, 4'b0101, 4'b0000, 4'hF);
    run_frame("R1", 0, 0, 4'h0, 2'd1, 1'b1, 32'hCAFE_0042, 8'h6D, 0, 4'b0101, 4'b1010, 4'hF);
    fall_sel = 1'b0;
    run_frame("R1", 0, 0, 4'h0, 2'd0, 1'b1, 32'h0000_0001, 8'h10, 0, 4'b0101, 4'b0000, 4'hF);

    finished = 1'b1;
    summary();
  end

endmodule